// File: doc/BRIEF.md
# Compare Output Pin Driver with Software Force

This block owns one compare output pin of a timer channel. When the counter reports a compare match, the block changes the pin according to a 2-bit output mode. It also issues a one-cycle pulse that sets the channel's interrupt flag, and when clear-on-match counting is active it asks the counter to restart. Software can also write a force strobe. A force applies the same pin action as a real match, using whatever output mode is present in that cycle. It never touches the interrupt flag or the counter.

Everything here applies only while the timer runs a non-PWM waveform. When the PWM flag is high, this block leaves the pin alone and ignores both matches and forces. PWM waveform shaping and the counter belong to neighbouring logic.

All outputs are registered. The effect of an input seen at one rising clock edge appears on the outputs right after that edge.

Top module: `cmpout_unit`

## Requirements
- R1: While reset is asserted (rstN low), pinLevel equals the parameter RESET_LEVEL (default 0), and irqSetPulse and counterClear are 0.
- R2: When matchPulse is 1 at a rising edge and pwmActive is 0, the pin takes the action selected by outMode, visible after that edge: 2'b00 leaves it unchanged, 2'b01 inverts it, 2'b10 drives it to 0, and 2'b11 drives it to 1.
- R3: When matchPulse is 1 and pwmActive is 0 at a rising edge, irqSetPulse is 1 for the following cycle. In every other case irqSetPulse is 0 for that cycle.
- R4: When matchPulse, ctcActive are 1 and pwmActive is 0 at a rising edge, counterClear is 1 for the following cycle. Otherwise counterClear is 0.
- R5: When forceStrobe is 1 at a rising edge and pwmActive is 0, the pin takes the outMode action of R2, using the outMode value sampled at that same edge.
- R6: A force strobe without a real match leaves irqSetPulse at 0.
- R7: A force strobe without a real match leaves counterClear at 0, including when ctcActive is 1.
- R8: While pwmActive is 1, matchPulse and forceStrobe change neither pinLevel, irqSetPulse nor counterClear.
- R9: When matchPulse and forceStrobe are both 1 at the same edge, the pin action is applied once; for example, a toggle inverts the pin a single time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| matchPulse | input | 1 | One-cycle compare match indication from the counter |
| outMode | input | 2 | Pin action on match: 00 keep, 01 toggle, 10 low, 11 high |
| pwmActive | input | 1 | High while a PWM waveform mode is selected |
| ctcActive | input | 1 | High while clear-on-match counting uses this channel as TOP |
| forceStrobe | input | 1 | Write-only software force, one cycle |
| pinLevel | output | 1 | Compare output pin level |
| irqSetPulse | output | 1 | Pulse that sets the channel interrupt flag |
| counterClear | output | 1 | Request to clear the counter |

## Verification
The case that is hardest to reach from the ports is a force and a real match in the same cycle, with the toggle mode selected and clear-on-match active. The result must show a single inversion of the pin, the interrupt pulse and the counter clear all together. An error is easy to miss here because a double toggle leaves the pin unchanged. Directed vectors drive this combination in every mode. Seeded random vectors assert match and force often enough that the coincidence recurs many times, with mode and PWM changing between cycles.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP   = 2'b00,
    MODE_TOGGLE = 2'b01,
    MODE_LOW    = 2'b10,
    MODE_HIGH   = 2'b11
  } pinMode_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic applyPin;
    logic raiseIrq;
    logic reqClear;
  } cmpStrobes_t;

  function automatic logic nextPin(input logic cur, input logic [1:0] mode);
    case (pinMode_t'(mode))
      MODE_TOGGLE: nextPin = ~cur;
      MODE_LOW:    nextPin = 1'b0;
      MODE_HIGH:   nextPin = 1'b1;
      default:     nextPin = cur;
    endcase
  endfunction

endpackage

// File: rtl/cmpout_ctrl.sv
module cmpout_ctrl
  import cmpout_pkg::*;
(
  input  logic        matchPulse,
  input  logic        forceStrobe,
  input  logic        pwmActive,
  input  logic        ctcActive,
  output cmpStrobes_t strobes
);

  logic realHit;
  logic forceHit;

  always_comb begin
    realHit  = matchPulse & ~pwmActive;
    forceHit = forceStrobe & ~pwmActive;
    // One pin action even when both sources coincide
    strobes.applyPin = realHit | forceHit;
    // Only a real match reaches the flag and the counter
    strobes.raiseIrq = realHit;
    strobes.reqClear = realHit & ctcActive;
  end

endmodule

// File: rtl/cmpout_datapath.sv
module cmpout_datapath
  import cmpout_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  cmpStrobes_t strobes,
  input  logic [1:0]  outMode,
  output logic        pinLevel,
  output logic        irqSetPulse,
  output logic        counterClear
);

  logic pinQ;
  logic irqQ;
  logic clrQ;
  logic pinD;

  always_comb begin
    pinD = pinQ;
    if (strobes.applyPin) pinD = nextPin(pinQ, outMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ <= RESET_LEVEL;
      irqQ <= 1'b0;
      clrQ <= 1'b0;
    end else begin
      pinQ <= pinD;
      irqQ <= strobes.raiseIrq;
      clrQ <= strobes.reqClear;
    end
  end

  assign pinLevel     = pinQ;
  assign irqSetPulse  = irqQ;
  assign counterClear = clrQ;

  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.applyPin && outMode == 2'b01) |=> (pinLevel != $past(pinLevel)));
  assert_drive_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.applyPin && outMode == 2'b10) |=> !pinLevel);
  assert_drive_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.applyPin && outMode == 2'b11) |=> pinLevel);
  assert_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outMode == 2'b00) |=> $stable(pinLevel));

endmodule

// File: rtl/cmpout_unit.sv
module cmpout_unit
  import cmpout_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       matchPulse,
  input  logic [1:0] outMode,
  input  logic       pwmActive,
  input  logic       ctcActive,
  input  logic       forceStrobe,
  output logic       pinLevel,
  output logic       irqSetPulse,
  output logic       counterClear
);

  cmpStrobes_t strobes;

  cmpout_ctrl uCtrl (
    .matchPulse  (matchPulse),
    .forceStrobe (forceStrobe),
    .pwmActive   (pwmActive),
    .ctcActive   (ctcActive),
    .strobes     (strobes)
  );

  cmpout_datapath #(.RESET_LEVEL(RESET_LEVEL)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .outMode      (outMode),
    .pinLevel     (pinLevel),
    .irqSetPulse  (irqSetPulse),
    .counterClear (counterClear)
  );

  assert_irq_on_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && !pwmActive) |=> irqSetPulse);
  assert_irq_needs_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqSetPulse) |-> $past(matchPulse));
  assert_clear_on_ctc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && ctcActive && !pwmActive) |=> counterClear);
  assert_force_no_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (forceStrobe && !matchPulse) |=> !irqSetPulse);
  assert_force_no_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (forceStrobe && !matchPulse) |=> !counterClear);
  assert_pwm_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    pwmActive |=> ($stable(pinLevel) && !irqSetPulse && !counterClear));
  assert_single_toggle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && forceStrobe && !pwmActive && outMode == 2'b01)
      |=> (pinLevel != $past(pinLevel)));

endmodule

// File: tb/sim_cmpout_unit.sv
module sim_cmpout_unit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       matchPulse, pwmActive, ctcActive, forceStrobe;
  logic [1:0] outMode;
  logic       pinLevel, irqSetPulse, counterClear;

  int vecCount  = 0;
  int failCount = 0;
  logic expPin;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpout_unit u0 (
    .clk(clk), .rstN(rstN), .matchPulse(matchPulse), .outMode(outMode),
    .pwmActive(pwmActive), .ctcActive(ctcActive), .forceStrobe(forceStrobe),
    .pinLevel(pinLevel), .irqSetPulse(irqSetPulse), .counterClear(counterClear)
  );

  function automatic logic modelPin(logic cur, logic [1:0] mode);
    case (mode)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check just after the rising edge
  task automatic step(logic m, logic f, logic p, logic c, logic [1:0] md);
    logic expIrq, expClr;
    string pinReq, irqReq, clrReq;
    @(negedge clk);
    matchPulse = m; forceStrobe = f; pwmActive = p; ctcActive = c; outMode = md;
    @(posedge clk);
    #1;
    if (!p && (m || f)) expPin = modelPin(expPin, md);
    expIrq = m && !p;
    expClr = m && c && !p;
    if (p)            pinReq = "R8";
    else if (m && f) pinReq = "R9";
    else if (f)      pinReq = "R5";
    else             pinReq = "R2";
    irqReq = p ? "R8" : ((f && !m) ? "R6" : "R3");
    clrReq = p ? "R8" : ((f && !m) ? "R7" : "R4");
    check(pinReq, pinLevel, expPin, "pinLevel");
    check(irqReq, irqSetPulse, expIrq, "irqSetPulse");
    check(clrReq, counterClear, expClr, "counterClear");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd7315));
    rstN = 1'b0; matchPulse = 0; forceStrobe = 0; pwmActive = 0;
    ctcActive = 0; outMode = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1", pinLevel, 1'b0, "pinLevel");
    check("R1", irqSetPulse, 1'b0, "irqSetPulse");
    check("R1", counterClear, 1'b0, "counterClear");
    expPin = 1'b0;
    @(negedge clk); rstN = 1'b1;

    // Directed: each mode via real match, then via force (R2, R5)
    for (int md = 0; md < 4; md++) begin
      step(1, 0, 0, 0, md[1:0]);
      step(0, 1, 0, 1, md[1:0]);
    end
    step(0, 0, 0, 0, 2'b11);
    // R7: force with clear-on-match active, toggle mode
    step(0, 1, 0, 1, 2'b01);
    // R9: coincident match and force in every mode, ctc on
    for (int md = 0; md < 4; md++) step(1, 1, 0, 1, md[1:0]);
    // R4: match without ctc gives no clear
    step(1, 0, 0, 0, 2'b01);
    // R8: PWM mode ignores everything
    step(1, 1, 1, 1, 2'b01);
    step(0, 1, 1, 0, 2'b10);
    step(1, 0, 1, 1, 2'b11);
    // Held match toggles on every cycle
    repeat (3) step(1, 0, 0, 1, 2'b01);

    // Seeded random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1] | r[2], r[3] | (r[4] & r[5]), r[6] & r[7], r[8], r[10:9]);
    end

    @(negedge clk);
    matchPulse = 0; forceStrobe = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule